// File: doc/BRIEF.md
# Reset Cause Register

This block records why the device or one of its cores was last reset. It holds one flag for a whole-device reset and one flag per core for a core-level reset. A synchronous global reset event sets the device flag and wipes every core flag. A core reset request sets only that core's flag. Flags stay set until software clears them.

Software reads the flags through a read-only status word. It clears flags by writing to a separate clear word, where a 1 in a bit position clears the matching flag. Reading the clear word returns zero. The block's own power-on reset `por_n` puts the register in the state a global reset would leave.

Control and status pins are plain level signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `rst_cause_reg`

## Requirements
- R1: Status word layout: bit 31 is the global flag. Bit n (n = 0..3) is the local flag of core n. `rd_sel` = 0 selects the status word on `rd_data`.
- R2: After `por_n` is low, or one cycle after `glob_rst_evt` is high at a clock edge, the global flag reads 1 and all local flags read 0.
- R3: When `core_rst_req[n]` is high at a clock edge and `glob_rst_evt` is low, local flag n reads 1 from the next cycle.
- R4: Status bits 30:4 always read 0.
- R5: An edge with `clr_we` = 1 clears every flag whose position holds 1 in `clr_data`. Positions holding 0 leave their flag unchanged. Bit 31 of `clr_data` clears the global flag, and bits 3:0 clear the local flags.
- R6: A core reset request leaves the global flag and the other cores' flags unchanged.
- R7: The status word cannot be written. Only the clear word changes flags, and the clear word (`rd_sel` = 1) reads as all zeros.
- R8: Conflicts on the same edge resolve this way. A set wins over a clear of the same bit. A global event wins over core requests, so the local flags become 0.
- R9: Requests are sampled only at clock edges. A request held high for several cycles has the same effect as a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| glob_rst_evt | input | 1 | Global reset event, sampled at clock edge |
| core_rst_req | input | 4 | Per-core local reset requests, sampled at clock edge |
| clr_we | input | 1 | Write strobe for the clear word |
| clr_data | input | 32 | Write-one-to-clear data |
| rd_sel | input | 1 | 0 = status word, 1 = clear word |
| rd_data | output | 32 | Selected read word |

## Verification
The bench drives a single core pulse, mixed core patterns, and requests held for several cycles. These separate per-bit setting from disturbance of neighbouring flags and from level-versus-edge confusion. Clear writes carry all-zero data, single bits, reserved-bit ones and the global bit, which tells true W1C behaviour apart from plain writes. Same-edge collisions of set with clear and of global with local requests expose a wrong priority order.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_CLEAR  = 1'b1
  } rd_sel_e;
endpackage

// File: rtl/rcr_core_flag.sv
module rcr_core_flag (
  input  logic clk,
  input  logic por_n,
  input  logic glob_evt,
  input  logic set_req,
  input  logic clr_req,
  output logic flag_q
);
  logic flag_d;

  // Global wipe first, then set beats clear.
  always_comb begin
    if (glob_evt)      flag_d = 1'b0;
    else if (set_req)  flag_d = 1'b1;
    else if (clr_req)  flag_d = 1'b0;
    else               flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end
endmodule

// File: rtl/rcr_glob_flag.sv
module rcr_glob_flag (
  input  logic clk,
  input  logic por_n,
  input  logic glob_evt,
  input  logic clr_req,
  output logic flag_q
);
  logic flag_d;

  always_comb begin
    if (glob_evt)     flag_d = 1'b1;
    else if (clr_req) flag_d = 1'b0;
    else              flag_d = flag_q;
  end

  // Power-on counts as a global reset.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) flag_q <= 1'b1;
    else        flag_q <= flag_d;
  end
endmodule

// File: rtl/rcr_clr_decode.sv
module rcr_clr_decode #(
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32,
  parameter int GLOB_POS  = 31
) (
  input  logic                 clr_we,
  input  logic [DATA_W-1:0]    clr_data,
  output logic [NUM_CORES-1:0] clr_lr,
  output logic                 clr_gr
);
  // Reserved positions are accepted but do nothing.
  logic unused_rsv;
  assign unused_rsv = ^{clr_data[GLOB_POS-1:NUM_CORES]};

  assign clr_lr = clr_we ? clr_data[NUM_CORES-1:0] : '0;
  assign clr_gr = clr_we & clr_data[GLOB_POS];
endmodule

// File: rtl/rcr_read_mux.sv
module rcr_read_mux
  import rcr_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32,
  parameter int GLOB_POS  = 31
) (
  input  logic                 rd_sel,
  input  logic                 gr_flag,
  input  logic [NUM_CORES-1:0] lr_flags,
  output logic [DATA_W-1:0]    rd_data
);
  logic [DATA_W-1:0] status_word;

  always_comb begin
    status_word = '0;
    status_word[NUM_CORES-1:0] = lr_flags;
    status_word[GLOB_POS] = gr_flag;
  end

  always_comb begin
    case (rd_sel_e'(rd_sel))
      SEL_STATUS: rd_data = status_word;
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg #(
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32,
  parameter int GLOB_POS  = 31
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 glob_rst_evt,
  input  logic [NUM_CORES-1:0] core_rst_req,
  input  logic                 clr_we,
  input  logic [DATA_W-1:0]    clr_data,
  input  logic                 rd_sel,
  output logic [DATA_W-1:0]    rd_data
);
  localparam int RSV_LO = NUM_CORES;

  logic [NUM_CORES-1:0] lr_flags;
  logic [NUM_CORES-1:0] clr_lr;
  logic                 clr_gr;
  logic                 gr_flag;

  initial begin
    if (RSV_LO > GLOB_POS || GLOB_POS >= DATA_W)
      $error("rst_cause_reg: bad field layout parameters");
  end

  rcr_clr_decode #(.NUM_CORES(NUM_CORES), .DATA_W(DATA_W), .GLOB_POS(GLOB_POS)) u_dec (
    .clr_we   (clr_we),
    .clr_data (clr_data),
    .clr_lr   (clr_lr),
    .clr_gr   (clr_gr)
  );

  rcr_glob_flag u_gr (
    .clk      (clk),
    .por_n    (por_n),
    .glob_evt (glob_rst_evt),
    .clr_req  (clr_gr),
    .flag_q   (gr_flag)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    rcr_core_flag u_lr (
      .clk      (clk),
      .por_n    (por_n),
      .glob_evt (glob_rst_evt),
      .set_req  (core_rst_req[c]),
      .clr_req  (clr_lr[c]),
      .flag_q   (lr_flags[c])
    );
  end

  rcr_read_mux #(.NUM_CORES(NUM_CORES), .DATA_W(DATA_W), .GLOB_POS(GLOB_POS)) u_rd (
    .rd_sel   (rd_sel),
    .gr_flag  (gr_flag),
    .lr_flags (lr_flags),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/rst_cause_chk.sv
module rst_cause_chk #(
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32,
  parameter int GLOB_POS  = 31
) (
  input logic                 clk,
  input logic                 por_n,
  input logic                 glob_rst_evt,
  input logic [NUM_CORES-1:0] core_rst_req,
  input logic                 clr_we,
  input logic [NUM_CORES-1:0] clr_lr_bits,
  input logic                 clr_gr_bit,
  input logic                 rd_sel,
  input logic [DATA_W-1:0]    rd_data,
  input logic                 gr_flag,
  input logic [NUM_CORES-1:0] lr_flags
);
  localparam logic [DATA_W-1:0] RSV_MASK =
    ~(({DATA_W{1'b0}} | {NUM_CORES{1'b1}}) | ({{(DATA_W-1){1'b0}}, 1'b1} << GLOB_POS));

  // R2
  p_glob_sets_r2: assert property (@(posedge clk) disable iff (!por_n)
    glob_rst_evt |=> (gr_flag && lr_flags == '0));

  // R3
  p_local_sets_r3: assert property (@(posedge clk) disable iff (!por_n)
    !glob_rst_evt |=> ((lr_flags & $past(core_rst_req)) == $past(core_rst_req)));

  // R6
  p_others_hold_r6: assert property (@(posedge clk) disable iff (!por_n)
    (!glob_rst_evt && !clr_we) |=>
      (gr_flag == $past(gr_flag) && lr_flags == ($past(lr_flags) | $past(core_rst_req))));

  // R5 and R8
  p_clear_local_r5: assert property (@(posedge clk) disable iff (!por_n)
    (!glob_rst_evt && clr_we) |=>
      (lr_flags == (($past(lr_flags) & ~$past(clr_lr_bits)) | $past(core_rst_req))));

  p_clear_glob_r5: assert property (@(posedge clk) disable iff (!por_n)
    (!glob_rst_evt && clr_we && clr_gr_bit) |=> !gr_flag);

  // R4
  p_reserved_zero_r4: assert property (@(posedge clk) disable iff (!por_n)
    (rd_data & RSV_MASK) == '0);

  // R7
  p_clear_word_zero_r7: assert property (@(posedge clk) disable iff (!por_n)
    rd_sel |-> rd_data == '0);

  // R1
  p_layout_r1: assert property (@(posedge clk) disable iff (!por_n)
    !rd_sel |-> (rd_data[GLOB_POS] == gr_flag && rd_data[NUM_CORES-1:0] == lr_flags));
endmodule

bind rst_cause_reg rst_cause_chk #(
  .NUM_CORES(NUM_CORES), .DATA_W(DATA_W), .GLOB_POS(GLOB_POS)
) i_chk (
  .clk          (clk),
  .por_n        (por_n),
  .glob_rst_evt (glob_rst_evt),
  .core_rst_req (core_rst_req),
  .clr_we       (clr_we),
  .clr_lr_bits  (clr_data[NUM_CORES-1:0]),
  .clr_gr_bit   (clr_data[GLOB_POS]),
  .rd_sel       (rd_sel),
  .rd_data      (rd_data),
  .gr_flag      (gr_flag),
  .lr_flags     (lr_flags)
);

// File: tb/test_rst_cause_reg.sv
`timescale 1ns/1ps
module test_rst_cause_reg;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        glob_rst_evt = 1'b0;
  logic [3:0]  core_rst_req = '0;
  logic        clr_we = 1'b0;
  logic [31:0] clr_data = '0;
  logic        rd_sel = 1'b0;
  logic [31:0] rd_data;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string tag = "R2";

  // behavioural reference state
  bit       m_gr = 1'b1;
  bit [3:0] m_lr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_cause_reg i_rst_cause_reg (
    .clk(clk), .por_n(por_n), .glob_rst_evt(glob_rst_evt),
    .core_rst_req(core_rst_req), .clr_we(clr_we), .clr_data(clr_data),
    .rd_sel(rd_sel), .rd_data(rd_data)
  );

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_gr = 1'b1; m_lr = '0;
    end else if (glob_rst_evt) begin
      m_gr = 1'b1; m_lr = '0;
    end else begin
      for (int i = 0; i < NC; i++) begin
        if (core_rst_req[i])                 m_lr[i] = 1'b1;
        else if (clr_we && clr_data[i])      m_lr[i] = 1'b0;
      end
      if (clr_we && clr_data[31]) m_gr = 1'b0;
    end
  end

  function automatic logic [31:0] exp_status();
    logic [31:0] w = '0;
    w[31] = m_gr;
    w[3:0] = m_lr;
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h t=%0t", req, got, exp, $time);
    end
  endtask

  // per-cycle compare, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      check(tag, rd_data, exp_status());
      check("R4", rd_data & 32'h7FFF_FFF0, 32'h0);
      #2 rd_sel = 1'b1;
      #1 check("R7", rd_data, 32'h0);
      rd_sel = 1'b0;
    end
  end

  task automatic step(input bit g, input logic [3:0] req, input bit we, input logic [31:0] d);
    @(negedge clk);
    #1;
    glob_rst_evt = g; core_rst_req = req; clr_we = we; clr_data = d;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, 4'h0, 1'b0, 32'h0);
  endtask

  initial begin
    tag = "R2";
    repeat (3) @(negedge clk);
    check("R2", rd_data, 32'h8000_0000); // reset state
    #1 por_n = 1'b1;
    idle(2);
    tag = "R3";  step(0, 4'b0010, 0, 0); idle(2);
    check("R3", rd_data, 32'h8000_0002);
    tag = "R5";  step(0, 0, 1, 32'h0); idle(1);
    check("R5", rd_data, 32'h8000_0002);
    step(0, 0, 1, 32'h0000_0002); idle(1);
    check("R5", rd_data, 32'h8000_0000);
    step(0, 0, 1, 32'h8000_0000); idle(1);
    check("R5", rd_data, 32'h0000_0000);
    tag = "R6";  step(0, 4'b1010, 0, 0); step(0, 4'b0101, 0, 0); idle(1);
    check("R6", rd_data, 32'h0000_000F);
    tag = "R7";  step(0, 0, 1, 32'h7FFF_FFF0); idle(1);
    check("R7", rd_data, 32'h0000_000F);
    tag = "R8";  step(0, 4'b0100, 1, 32'h0000_000C); idle(1);
    check("R8", rd_data, 32'h0000_0007);
    step(1, 4'b1000, 0, 0); idle(1);
    check("R8", rd_data, 32'h8000_0000);
    step(0, 0, 1, 32'h8000_0000); step(1, 0, 1, 32'h8000_0000); idle(1);
    check("R8", rd_data, 32'h8000_0000);
    tag = "R9";  step(0, 0, 1, 32'hFFFF_FFFF);
    step(0, 4'b0001, 0, 0); step(0, 4'b0001, 0, 0); step(0, 4'b0001, 0, 0); idle(1);
    check("R9", rd_data, 32'h0000_0001);
    step(0, 0, 1, 32'h0000_0001); idle(1);
    check("R9", rd_data, 32'h0000_0000);
    tag = "R2";  step(0, 4'hF, 0, 0); step(1, 0, 0, 0); idle(2);
    check("R2", rd_data, 32'h8000_0000);
    tag = "R1";  step(0, 4'b1001, 0, 0); idle(1);
    check("R1", rd_data, 32'h8000_0009);
    idle(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule